// File: doc/BRIEF.md
# EDID Mailbox Readout Sequencer

This block is a hardware master that copies a 128-byte display identification block out of a mailbox register bank maintained by a separate firmware agent. The mailbox hands out the block one 4-byte word at a time. The sequencer writes a word pointer, polls an echo register until the firmware confirms that word, and then reads the four data bytes. The bytes go out on a valid/data/index stream. The sequencer patches the last word so that the block reports no extension blocks and its checksum still sums to zero. It finishes with a done pulse or an error pulse with a code.

The bank is reached through a simple synchronous port. A read issued in one cycle returns its data on `regRdData` in the next cycle. Writes take effect at the clock edge. An external millisecond tick paces the retry backoff. A start pulse launches one readout.

Register map, in 3-bit addresses:
- 0: status, with bit 0 = firmware running, bit 1 = link up, bit 2 = display plugged.
- 1: control, with bit 0 = host read-done flag.
- 2: word pointer.
- 3: echo, with bit 7 = valid and bits 5:0 = echoed pointer.
- 4 to 7: data bytes 0 to 3 of the current word.

Top module: `edid_mbox_reader`

## Requirements
- R1: A start pulse while idle raises `busy` in the next cycle and begins a readout. Start pulses while `busy` is high are ignored, so the readout still produces exactly 32 pointer writes and one done pulse.
- R2: At start the status register (address 0) and the control register (address 1) are read. If the firmware, link or plug bit is clear, or the read-done bit is clear, the block aborts with error code 1, 2, 3 or 4 respectively. The first failing check wins, in that order. On this path no pointer is written and the control register is not written.
- R3: Before the first pointer write, the read-done bit is cleared by writing 0 to address 1. After a successful readout, and after any abort once words are being fetched, 1 is written to address 1.
- R4: Pointers 0 to 31 are written to address 2 in ascending order, one per word.
- R5: A word's data is read only after an echo read returns bit 7 = 1 and bits 5:0 equal to the written pointer. A clear valid bit or a stale pointer both count as a miss.
- R6: After the miss with retry number j (counting from 0 for each word), the block waits j+1 millisecond ticks before polling again. With `msTick` held high, consecutive echo reads for one word are j+5 cycles apart.
- R7: After every backoff wait the status register is read again. If firmware, link or plug is clear, the block aborts with error code 6.
- R8: If the echo still misses after the wait for retry number MAX_RETRY (default 200), the block aborts with error code 5. Exactly MAX_RETRY+1 echo reads are made for that word.
- R9: Each data byte is emitted once on `byteValid`/`byteData`/`byteIndex`. Indices run 0 to 127 in order. Byte k of word w (read from address 4+k) has index 4w+k.
- R10: In the last word, index 126 carries 0 and index 127 carries the sum modulo 256 of the raw bytes 126 and 127.
- R11: Completion gives a one-cycle `donePulse` with `errCode` 0. An abort gives a one-cycle `errPulse`, with `errCode` held until the next start. The two pulses never coincide, and `busy` is low during either pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Begin a readout when idle |
| msTick | input | 1 | One-cycle millisecond tick |
| regAddr | output | 3 | Bank address |
| regRdEn | output | 1 | Read request, data next cycle |
| regWrEn | output | 1 | Write strobe |
| regWrData | output | 8 | Write data |
| regRdData | input | 8 | Read data from the previous request |
| byteValid | output | 1 | Stream byte valid |
| byteData | output | 8 | Stream byte |
| byteIndex | output | 7 | Stream byte position, 0 to 127 |
| busy | output | 1 | Readout in progress |
| donePulse | output | 1 | Successful completion |
| errPulse | output | 1 | Aborted completion |
| errCode | output | 3 | 0 none, 1 to 4 not-ready cause, 5 retries exhausted, 6 link lost |

## Verification
Most control faults show up on the register port within a few cycles. A wrong word counter shows at the next pointer write. A skipped clear of the read-done flag shows at the first pointer write. A lost retry count shows as the wrong spacing between echo reads. Datapath faults show at the stream: a bad byte index or a missed tail patch is visible at the end of the run, when all 128 captured bytes are compared. Wrong priority among the readiness checks shows within four cycles of start, as a wrong code.

// File: rtl/edid_mbox_pkg.sv
package edid_mbox_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_STAT  = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd1;
  localparam logic [ADDR_W-1:0] A_PTR   = 3'd2;
  localparam logic [ADDR_W-1:0] A_ECHO  = 3'd3;
  localparam logic [ADDR_W-1:0] A_DATA0 = 3'd4;
  localparam int ECHO_VALID_BIT = 7;
  localparam int ECHO_PTR_W = 6;

  typedef enum logic [2:0] {
    ERR_NONE      = 3'd0,
    ERR_NO_FW     = 3'd1,
    ERR_NO_LINK   = 3'd2,
    ERR_NO_PLUG   = 3'd3,
    ERR_NOT_DONE  = 3'd4,
    ERR_RETRY     = 3'd5,
    ERR_LINK_LOST = 3'd6
  } err_e;

  typedef struct packed {
    logic clrWord;
    logic incWord;
    logic clrByte;
    logic incByte;
    logic clrRetry;
    logic incRetry;
    logic loadDelay;
    logic countDelay;
    logic capture;
  } strobe_t;
endpackage

// File: rtl/edid_mbox_datapath.sv
module edid_mbox_datapath
  import edid_mbox_pkg::*;
#(
  parameter int WORDS = 32,
  parameter int BPW = 4,
  parameter int MAX_RETRY = 200,
  localparam int WORD_W = $clog2(WORDS),
  localparam int BSEL_W = $clog2(BPW),
  localparam int IDX_W = $clog2(WORDS * BPW),
  localparam int RETRY_W = $clog2(MAX_RETRY + 2)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic              msTick,
  input  logic [7:0]        rdData,
  output logic [WORD_W-1:0] wordIdx,
  output logic [BSEL_W-1:0] byteSel,
  output logic              lastWord,
  output logic              lastByte,
  output logic              retryAtMax,
  output logic              delayDone,
  output logic              echoOk,
  output logic              outValid,
  output logic [7:0]        outData,
  output logic [IDX_W-1:0]  outIdx
);
  logic [RETRY_W-1:0] retryCnt;
  logic [RETRY_W-1:0] delayCnt;
  logic [7:0] heldByte;
  logic tailLow, tailHigh;

  assign lastWord   = (wordIdx == WORD_W'(WORDS - 1));
  assign lastByte   = (byteSel == BSEL_W'(BPW - 1));
  assign retryAtMax = (retryCnt == RETRY_W'(MAX_RETRY));
  assign delayDone  = stb.countDelay && msTick && (delayCnt == RETRY_W'(1));
  assign echoOk     = rdData[ECHO_VALID_BIT] &&
                      (rdData[ECHO_PTR_W-1:0] == ECHO_PTR_W'(wordIdx));
  assign tailLow    = lastWord && (byteSel == BSEL_W'(BPW - 2));
  assign tailHigh   = lastWord && lastByte;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordIdx  <= '0;
      byteSel  <= '0;
      retryCnt <= '0;
      delayCnt <= '0;
    end else begin
      if (stb.clrWord)      wordIdx <= '0;
      else if (stb.incWord) wordIdx <= wordIdx + 1'b1;
      if (stb.clrByte)      byteSel <= '0;
      else if (stb.incByte) byteSel <= byteSel + 1'b1;
      if (stb.clrRetry)      retryCnt <= '0;
      else if (stb.incRetry) retryCnt <= retryCnt + 1'b1;
      if (stb.loadDelay)                    delayCnt <= retryCnt + 1'b1;
      else if (stb.countDelay && msTick)    delayCnt <= delayCnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
      outIdx   <= '0;
      heldByte <= '0;
    end else begin
      outValid <= stb.capture;
      if (stb.capture) begin
        outIdx <= IDX_W'(wordIdx * BPW) + IDX_W'(byteSel);
        if (tailLow) begin
          heldByte <= rdData;
          outData  <= 8'd0;
        end else if (tailHigh) begin
          outData <= rdData + heldByte;
        end else begin
          outData <= rdData;
        end
      end
    end
  end

  logic [IDX_W-1:0] prevIdx;
  always_ff @(posedge clk) begin
    if (!rstN) prevIdx <= '0;
    else if (outValid) prevIdx <= outIdx;
  end

  AST_RETRY_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    retryCnt <= RETRY_W'(MAX_RETRY)); // R8
  AST_INDEX_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outIdx != '0) |-> (outIdx == prevIdx + 1'b1)); // R9
endmodule

// File: rtl/edid_mbox_control.sv
module edid_mbox_control
  import edid_mbox_pkg::*;
#(
  parameter int WORDS = 32,
  parameter int BPW = 4,
  localparam int WORD_W = $clog2(WORDS),
  localparam int BSEL_W = $clog2(BPW)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic [7:0]        regRdData,
  input  logic [WORD_W-1:0] wordIdx,
  input  logic [BSEL_W-1:0] byteSel,
  input  logic              lastWord,
  input  logic              lastByte,
  input  logic              retryAtMax,
  input  logic              delayDone,
  input  logic              echoOk,
  output strobe_t           stb,
  output logic [ADDR_W-1:0] regAddr,
  output logic              regRdEn,
  output logic              regWrEn,
  output logic [7:0]        regWrData,
  output logic              busy,
  output logic              donePulse,
  output logic              errPulse,
  output logic [2:0]        errCode
);
  typedef enum logic [3:0] {
    S_IDLE, S_RD_STAT, S_CK_STAT, S_RD_CTRL, S_CK_CTRL, S_CLR,
    S_WR_PTR, S_RD_ECHO, S_CK_ECHO, S_WAIT, S_RD_LINK, S_CK_LINK,
    S_RD_BYTE, S_CK_BYTE, S_FIN, S_ABORT
  } state_e;

  state_e state, stateN;
  logic finOk, errFire, errLoad, accept;
  err_e errLoadVal;
  logic linkHealthy;

  assign busy = (state != S_IDLE);
  assign accept = (state == S_IDLE) && startPulse;
  assign linkHealthy = regRdData[0] && regRdData[1] && regRdData[2];

  always_comb begin
    stateN = state;
    stb = '0;
    regAddr = A_STAT;
    regRdEn = 1'b0;
    regWrEn = 1'b0;
    regWrData = 8'd0;
    finOk = 1'b0;
    errFire = 1'b0;
    errLoad = 1'b0;
    errLoadVal = ERR_NONE;
    unique case (state)
      S_IDLE: if (startPulse) stateN = S_RD_STAT;
      S_RD_STAT: begin
        regRdEn = 1'b1;
        stateN = S_CK_STAT;
      end
      S_CK_STAT: begin
        if (!regRdData[0]) begin
          errLoad = 1'b1; errLoadVal = ERR_NO_FW; errFire = 1'b1; stateN = S_IDLE;
        end else if (!regRdData[1]) begin
          errLoad = 1'b1; errLoadVal = ERR_NO_LINK; errFire = 1'b1; stateN = S_IDLE;
        end else if (!regRdData[2]) begin
          errLoad = 1'b1; errLoadVal = ERR_NO_PLUG; errFire = 1'b1; stateN = S_IDLE;
        end else begin
          stateN = S_RD_CTRL;
        end
      end
      S_RD_CTRL: begin
        regAddr = A_CTRL;
        regRdEn = 1'b1;
        stateN = S_CK_CTRL;
      end
      S_CK_CTRL: begin
        if (!regRdData[0]) begin
          errLoad = 1'b1; errLoadVal = ERR_NOT_DONE; errFire = 1'b1; stateN = S_IDLE;
        end else begin
          stateN = S_CLR;
        end
      end
      S_CLR: begin
        regAddr = A_CTRL;
        regWrEn = 1'b1;
        regWrData = 8'd0;
        stb.clrWord = 1'b1;
        stb.clrByte = 1'b1;
        stateN = S_WR_PTR;
      end
      S_WR_PTR: begin
        regAddr = A_PTR;
        regWrEn = 1'b1;
        regWrData = 8'(wordIdx);
        stb.clrRetry = 1'b1;
        stateN = S_RD_ECHO;
      end
      S_RD_ECHO: begin
        regAddr = A_ECHO;
        regRdEn = 1'b1;
        stateN = S_CK_ECHO;
      end
      S_CK_ECHO: begin
        if (echoOk) begin
          stateN = S_RD_BYTE;
        end else begin
          stb.loadDelay = 1'b1;
          stateN = S_WAIT;
        end
      end
      S_WAIT: begin
        stb.countDelay = 1'b1;
        if (delayDone) stateN = S_RD_LINK;
      end
      S_RD_LINK: begin
        regRdEn = 1'b1;
        stateN = S_CK_LINK;
      end
      S_CK_LINK: begin
        if (!linkHealthy) begin
          errLoad = 1'b1; errLoadVal = ERR_LINK_LOST; stateN = S_ABORT;
        end else if (retryAtMax) begin
          errLoad = 1'b1; errLoadVal = ERR_RETRY; stateN = S_ABORT;
        end else begin
          stb.incRetry = 1'b1;
          stateN = S_RD_ECHO;
        end
      end
      S_RD_BYTE: begin
        regAddr = ADDR_W'(A_DATA0 + ADDR_W'(byteSel));
        regRdEn = 1'b1;
        stateN = S_CK_BYTE;
      end
      S_CK_BYTE: begin
        stb.capture = 1'b1;
        if (lastByte) begin
          stb.clrByte = 1'b1;
          if (lastWord) begin
            stateN = S_FIN;
          end else begin
            stb.incWord = 1'b1;
            stateN = S_WR_PTR;
          end
        end else begin
          stb.incByte = 1'b1;
          stateN = S_RD_BYTE;
        end
      end
      S_FIN: begin
        regAddr = A_CTRL;
        regWrEn = 1'b1;
        regWrData = 8'd1;
        finOk = 1'b1;
        stateN = S_IDLE;
      end
      S_ABORT: begin
        regAddr = A_CTRL;
        regWrEn = 1'b1;
        regWrData = 8'd1;
        errFire = 1'b1;
        stateN = S_IDLE;
      end
      default: stateN = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      donePulse <= 1'b0;
      errPulse <= 1'b0;
      errCode <= ERR_NONE;
    end else begin
      state <= stateN;
      donePulse <= finOk;
      errPulse <= errFire;
      if (accept) errCode <= ERR_NONE;
      else if (errLoad) errCode <= errLoadVal;
    end
  end

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startPulse) |=> (state != S_RD_STAT)); // R1
  AST_ERR_HAS_CODE: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> (errCode != ERR_NONE)); // R2
  AST_DONE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> $past(regWrEn && regAddr == A_CTRL && regWrData[0])); // R3
  AST_PTR_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == A_PTR) |-> (regWrData < 8'(WORDS))); // R4
  AST_SINGLE_OUTCOME: assert property (@(posedge clk) disable iff (!rstN)
    !(donePulse && errPulse)); // R11
endmodule

// File: rtl/edid_mbox_reader.sv
module edid_mbox_reader
  import edid_mbox_pkg::*;
#(
  parameter int WORDS = 32,
  parameter int BPW = 4,
  parameter int MAX_RETRY = 200,
  localparam int WORD_W = $clog2(WORDS),
  localparam int BSEL_W = $clog2(BPW),
  localparam int IDX_W = $clog2(WORDS * BPW)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic             msTick,
  output logic [2:0]       regAddr,
  output logic             regRdEn,
  output logic             regWrEn,
  output logic [7:0]       regWrData,
  input  logic [7:0]       regRdData,
  output logic             byteValid,
  output logic [7:0]       byteData,
  output logic [IDX_W-1:0] byteIndex,
  output logic             busy,
  output logic             donePulse,
  output logic             errPulse,
  output logic [2:0]       errCode
);
  strobe_t stb;
  logic [WORD_W-1:0] wordIdx;
  logic [BSEL_W-1:0] byteSel;
  logic lastWord, lastByte, retryAtMax, delayDone, echoOk;

  edid_mbox_control #(.WORDS(WORDS), .BPW(BPW)) u_ctl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .regRdData(regRdData),
    .wordIdx(wordIdx), .byteSel(byteSel), .lastWord(lastWord), .lastByte(lastByte),
    .retryAtMax(retryAtMax), .delayDone(delayDone), .echoOk(echoOk), .stb(stb),
    .regAddr(regAddr), .regRdEn(regRdEn), .regWrEn(regWrEn), .regWrData(regWrData),
    .busy(busy), .donePulse(donePulse), .errPulse(errPulse), .errCode(errCode)
  );

  edid_mbox_datapath #(.WORDS(WORDS), .BPW(BPW), .MAX_RETRY(MAX_RETRY)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .msTick(msTick), .rdData(regRdData),
    .wordIdx(wordIdx), .byteSel(byteSel), .lastWord(lastWord), .lastByte(lastByte),
    .retryAtMax(retryAtMax), .delayDone(delayDone), .echoOk(echoOk),
    .outValid(byteValid), .outData(byteData), .outIdx(byteIndex)
  );
endmodule

// File: tb/edid_mbox_reader_bench.sv
module edid_mbox_reader_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startPulse = 1'b0;
  logic msTick = 1'b1;
  logic [2:0] regAddr;
  logic regRdEn, regWrEn;
  logic [7:0] regWrData;
  logic [7:0] regRdData;
  logic byteValid;
  logic [7:0] byteData;
  logic [6:0] byteIndex;
  logic busy, donePulse, errPulse;
  logic [2:0] errCode;

  always #2 clk = ~clk;

  edid_mbox_reader u_edid_mbox_reader (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .msTick(msTick),
    .regAddr(regAddr), .regRdEn(regRdEn), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .byteValid(byteValid), .byteData(byteData),
    .byteIndex(byteIndex), .busy(busy), .donePulse(donePulse), .errPulse(errPulse),
    .errCode(errCode)
  );

  int total = 0;
  int bad = 0;

  // Mailbox model
  logic fwOk = 1'b1, linkOk = 1'b1, plugOk = 1'b1;
  logic ctrlReg = 1'b1;
  logic [7:0] ptrReg = 8'd0;
  int echoCnt = 0;
  int lag = 0;

  function automatic logic [7:0] srcByte(int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  always @(posedge clk) begin
    if (regWrEn) begin
      if (regAddr == 3'd1) ctrlReg <= regWrData[0];
      if (regAddr == 3'd2) begin
        ptrReg <= regWrData;
        echoCnt <= 0;
      end
    end
    if (regRdEn) begin
      case (regAddr)
        3'd0: regRdData <= {5'd0, plugOk, linkOk, fwOk};
        3'd1: regRdData <= {7'd0, ctrlReg};
        3'd3: begin
          if (echoCnt < lag)
            regRdData <= echoCnt[0] ? {2'b10, 6'(ptrReg + 8'd1)} : {2'b00, ptrReg[5:0]};
          else
            regRdData <= {2'b10, ptrReg[5:0]};
          echoCnt <= echoCnt + 1;
        end
        3'd4, 3'd5, 3'd6, 3'd7:
          regRdData <= srcByte(int'(ptrReg) * 4 + int'(regAddr) - 4);
        default: regRdData <= 8'd0;
      endcase
    end
  end

  // Monitors, sampled away from the active edge
  int cyc = 0;
  int rxCount = 0, doneCnt = 0, errCnt = 0, ptrWrCnt = 0, echoTotal = 0, ctrlWrCnt = 0;
  int ctrlAtFirstPtr = -1;
  int echoTimes[8];
  logic [7:0] rx[128];
  logic [7:0] ptrLog[32];
  logic [2:0] lastErr = 3'd0;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (byteValid) begin
      rx[byteIndex] <= byteData;
      rxCount <= rxCount + 1;
    end
    if (donePulse) doneCnt <= doneCnt + 1;
    if (errPulse) begin
      errCnt <= errCnt + 1;
      lastErr <= errCode;
    end
    if (regWrEn && regAddr == 3'd1) ctrlWrCnt <= ctrlWrCnt + 1;
    if (regWrEn && regAddr == 3'd2) begin
      if (ptrWrCnt == 0) ctrlAtFirstPtr <= int'(ctrlReg);
      if (ptrWrCnt < 32) ptrLog[ptrWrCnt] <= regWrData;
      ptrWrCnt <= ptrWrCnt + 1;
    end
    if (regRdEn && regAddr == 3'd3) begin
      if (ptrWrCnt == 1 && echoTotal < 8) echoTimes[echoTotal] <= cyc;
      echoTotal <= echoTotal + 1;
    end
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clearMon();
    @(negedge clk);
    rxCount = 0; doneCnt = 0; errCnt = 0; ptrWrCnt = 0; echoTotal = 0;
    ctrlWrCnt = 0; ctrlAtFirstPtr = -1;
  endtask

  task automatic pulseStart();
    @(negedge clk) startPulse = 1'b1;
    @(negedge clk) startPulse = 1'b0;
  endtask

  task automatic waitEnd(input int limit);
    int n = 0;
    while (doneCnt + errCnt == 0 && n < limit) begin
      @(negedge clk);
      n++;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic checkStream(input string tag);
    int mism = 0;
    chk(rxCount == 128, "R9 byte count", rxCount, 128);
    for (int i = 0; i < 126; i++) if (rx[i] !== srcByte(i)) mism++;
    chk(mism == 0, "R9 byte values", mism, 0);
    chk(rx[126] == 8'd0, "R10 extension count byte", int'(rx[126]), 0);
    chk(rx[127] == 8'(srcByte(126) + srcByte(127)), "R10 checksum byte",
        int'(rx[127]), int'(8'(srcByte(126) + srcByte(127))));
    mism = 0;
    for (int i = 0; i < 32; i++) if (ptrLog[i] != 8'(i)) mism++;
    chk(mism == 0 && ptrWrCnt == 32, "R4 pointer sequence", ptrWrCnt, 32);
    chk(ctrlAtFirstPtr == 0, "R3 read-done cleared before pointers", ctrlAtFirstPtr, 0);
    chk(ctrlReg == 1'b1, "R3 read-done set at end", int'(ctrlReg), 1);
    chk(doneCnt == 1 && errCnt == 0, "R11 single done pulse", doneCnt, 1);
    chk(errCode == 3'd0, "R11 error code clear", int'(errCode), 0);
    $display("  %s stream checked", tag);
  endtask

  task automatic testReset();
    chk(busy == 1'b0, "R11 reset busy", int'(busy), 0);
    chk(byteValid == 1'b0, "R9 reset stream idle", int'(byteValid), 0);
    chk(errCode == 3'd0 && !donePulse && !errPulse, "R11 reset outcome", int'(errCode), 0);
  endtask

  task automatic testClean();
    lag = 0;
    clearMon();
    pulseStart();
    chk(busy == 1'b1, "R1 busy after start", int'(busy), 1);
    waitEnd(20000);
    checkStream("clean");
    chk(echoTotal == 32, "R5 one echo read per word", echoTotal, 32);
  endtask

  task automatic testBackoff();
    int mism = 0;
    lag = 6;
    clearMon();
    pulseStart();
    waitEnd(40000);
    checkStream("backoff");
    chk(echoTotal == 32 * 7, "R5 misses on stale or invalid echo", echoTotal, 32 * 7);
    for (int j = 0; j < 6; j++) begin
      if (echoTimes[j + 1] - echoTimes[j] != j + 5) begin
        mism++;
        $display("FAIL R6 gap %0d actual=%0d expected=%0d", j,
                 echoTimes[j + 1] - echoTimes[j], j + 5);
      end
    end
    total++;
    if (mism != 0) bad++;
  endtask

  task automatic testBusyStart();
    lag = 1;
    clearMon();
    pulseStart();
    repeat (40) @(negedge clk);
    pulseStart();
    repeat (300) @(negedge clk);
    pulseStart();
    waitEnd(40000);
    chk(ptrWrCnt == 32, "R1 no restart while busy", ptrWrCnt, 32);
    chk(doneCnt == 1, "R1 single completion", doneCnt, 1);
    chk(rxCount == 128, "R1 stream intact", rxCount, 128);
  endtask

  task automatic testNotReady(input logic f, input logic l, input logic p,
                              input logic c, input int expCode, input string tag);
    fwOk = f; linkOk = l; plugOk = p; ctrlReg = c;
    clearMon();
    pulseStart();
    waitEnd(200);
    chk(errCnt == 1 && int'(lastErr) == expCode, tag, int'(lastErr), expCode);
    chk(ptrWrCnt == 0 && ctrlWrCnt == 0, "R2 no writes on not-ready",
        ptrWrCnt + ctrlWrCnt, 0);
    chk(busy == 1'b0 && int'(errCode) == expCode, "R11 code held after abort",
        int'(errCode), expCode);
    fwOk = 1; linkOk = 1; plugOk = 1; ctrlReg = 1;
  endtask

  task automatic testLinkLost();
    lag = 1000000;
    clearMon();
    pulseStart();
    while (echoTotal < 3) @(negedge clk);
    linkOk = 1'b0;
    waitEnd(5000);
    chk(errCnt == 1 && lastErr == 3'd6, "R7 link lost code", int'(lastErr), 6);
    chk(ctrlReg == 1'b1, "R3 read-done set after abort", int'(ctrlReg), 1);
    chk(rxCount == 0, "R7 no bytes after link loss", rxCount, 0);
    linkOk = 1'b1;
  endtask

  task automatic testRetries();
    lag = 1000000;
    clearMon();
    pulseStart();
    waitEnd(60000);
    chk(errCnt == 1 && lastErr == 3'd5, "R8 retries exhausted code", int'(lastErr), 5);
    chk(echoTotal == 201, "R8 echo read count", echoTotal, 201);
    chk(ctrlReg == 1'b1, "R3 read-done set after retry abort", int'(ctrlReg), 1);
    chk(doneCnt == 0, "R11 no done on abort", doneCnt, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testClean();
    testBackoff();
    testBusyStart();
    testNotReady(1'b0, 1'b0, 1'b1, 1'b1, 1, "R2 firmware first");
    testNotReady(1'b1, 1'b0, 1'b0, 1'b1, 2, "R2 link second");
    testNotReady(1'b1, 1'b1, 1'b0, 1'b0, 3, "R2 plug third");
    testNotReady(1'b1, 1'b1, 1'b1, 1'b0, 4, "R2 read-done last");
    testLinkLost();
    testRetries();
    testClean();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule